// File: doc/BRIEF.md
# Descriptor-Chained Transfer Controller

This block moves blocks of data words from a source region to a destination region without any per-channel setup registers. Each transfer is described by a four-word record kept in main memory. When one of the activation inputs pulses, the controller reads a pointer from that input's slot in a vector table. It then fetches the record the pointer selects and copies the requested number of words, one read followed by one write per word.

A record can ask for chaining. In that case the controller fetches the record stored immediately after it and runs it, with no processor involvement between links. When the final record of a chain finishes, the controller can optionally store the advanced source and destination addresses back into that record. It raises a one-cycle interrupt if the final record requests one.

Activations that arrive while a chain is in progress are latched. They are served after the chain ends, lowest input index first. All memory traffic uses one simple request/acknowledge port.

Top module: `chain_xfer`

## Requirements
- R1: After reset the block is idle: `busy_o`, `mem_req_o` and `irq_o` are low.
- R2: On activation of input k, the first memory read is the vector word at VEC_BASE + 4*k. The next four reads take the record words at P, P+4, P+8 and P+12, where P is the vector value. These words are, in that order: source address, destination address, element count and control word.
- R3: The control word bits are: bit 0 chain, bit 1 interrupt, bit 2 source increment, bit 3 destination increment, bit 4 write-back. For each element the block reads the source and then writes that value to the destination. An address advances by 4 after each element when its increment bit is set, and stays fixed otherwise.
- R4: A record with element count 0 causes no data read or write. Its chain, interrupt and write-back bits still take effect.
- R5: When a finished record has the chain bit set, the record at P+16 is fetched and executed automatically.
- R6: `irq_o` pulses for exactly one cycle after the last record of a chain. It pulses only when that record's interrupt bit is set. Interrupt bits in earlier records of the chain are ignored.
- R7: With the write-back bit set in the last record, the final (advanced) source address is written to word P and the final destination address to word P+4 of that record. The count word is left unchanged.
- R8: Activations arriving while busy are held and served after the chain ends, lowest index first. Repeated activations of an input that is already pending are served once.
- R9: Once `mem_req_o` is raised, it stays high with stable `mem_addr_o`, `mem_we_o` and `mem_wdata_o` until `mem_ack_i`. Each acknowledge completes exactly one access.
- R10: `busy_o` rises in the cycle after a pending activation is accepted and falls when the chain completes. `mem_req_o` is never high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| act_i | input | NREQ | Activation pulses, one per source |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address of the access |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Access done; read data valid |
| mem_rdata_i | input | DW | Read data |
| busy_o | output | 1 | A chain is being processed |
| irq_o | output | 1 | One-cycle completion interrupt |

## Verification
A corrupted fetch index or pointer shows up within one access as a wrong address on `mem_addr_o`: a vector slot or record word other than the one expected. The read log catches this at the start of each activation. A wrong element count or step corrupts or misses destination words, which are checked word by word once the chain goes idle, along with untouched guard words just past each region. A lost pending bit or wrong priority changes the order of vector reads, and a misplaced interrupt decision changes the pulse count. Both are visible within one chain.

// File: rtl/chain_xfer_pkg.sv
package chain_xfer_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_VEC, S_DESC, S_RD, S_WR, S_WB, S_LINK
  } seq_st_e;

  localparam int CTRL_W     = 5;
  localparam int CB_CHAIN   = 0;
  localparam int CB_IRQ     = 1;
  localparam int CB_SINC    = 2;
  localparam int CB_DINC    = 3;
  localparam int CB_WB      = 4;
  localparam int DESC_WORDS = 4;
endpackage

// File: rtl/chain_xfer_arb.sv
module chain_xfer_arb #(
  parameter int NREQ = 4,
  parameter int IW   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREQ-1:0] act_i,
  input  logic            take_i,
  output logic            gnt_vld_o,
  output logic [IW-1:0]   gnt_idx_o,
  output logic [NREQ-1:0] gnt_oh_o
);
  logic [NREQ-1:0] pend_q;

  // lowest index wins
  always_comb begin
    gnt_oh_o  = '0;
    gnt_idx_o = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        gnt_oh_o    = '0;
        gnt_oh_o[i] = 1'b1;
        gnt_idx_o   = IW'(i);
      end
    end
  end

  assign gnt_vld_o = |pend_q;

  // a new pulse on the granted source keeps it pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~(take_i ? gnt_oh_o : '0)) | act_i;
  end
endmodule

// File: rtl/chain_xfer_seq.sv
module chain_xfer_seq
  import chain_xfer_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter int          IW       = 2,
  parameter logic [31:0] VEC_BASE = 32'h0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gnt_vld_i,
  input  logic [IW-1:0] gnt_idx_i,
  output logic          take_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          irq_o
);
  localparam int          STEP      = DW / 8;
  localparam logic [AW-1:0] STEP_A  = AW'(STEP);
  localparam logic [AW-1:0] DESC_SZ = AW'(DESC_WORDS * STEP);

  seq_st_e             st_q;
  logic [IW-1:0]       idx_q;
  logic [AW-1:0]       ptr_q, src_q, dst_q;
  logic [DW-1:0]       cnt_q, data_q;
  logic [CTRL_W-1:0]   ctrl_q;
  logic [1:0]          widx_q;
  logic                irq_q;
  logic [AW-1:0]       word_addr;

  assign word_addr = ptr_q + STEP_A * AW'(widx_q);
  assign take_o    = (st_q == S_IDLE) && gnt_vld_i;
  assign busy_o    = (st_q != S_IDLE);
  assign irq_o     = irq_q;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      S_VEC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = AW'(VEC_BASE) + STEP_A * AW'(idx_q);
      end
      S_DESC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = word_addr;
      end
      S_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = src_q;
      end
      S_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dst_q;
        mem_wdata_o = data_q;
      end
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = word_addr;
        mem_wdata_o = (widx_q == 2'd0) ? DW'(src_q) : DW'(dst_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      ptr_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      data_q <= '0;
      ctrl_q <= '0;
      widx_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (gnt_vld_i) begin
          idx_q <= gnt_idx_i;
          st_q  <= S_VEC;
        end
        S_VEC: if (mem_ack_i) begin
          ptr_q  <= mem_rdata_i[AW-1:0];
          widx_q <= 2'd0;
          st_q   <= S_DESC;
        end
        S_DESC: if (mem_ack_i) begin
          unique case (widx_q)
            2'd0: src_q <= mem_rdata_i[AW-1:0];
            2'd1: dst_q <= mem_rdata_i[AW-1:0];
            2'd2: cnt_q <= mem_rdata_i;
            default: ctrl_q <= mem_rdata_i[CTRL_W-1:0];
          endcase
          if (widx_q == 2'd3) begin
            widx_q <= 2'd0;
            if (cnt_q == '0) st_q <= mem_rdata_i[CB_WB] ? S_WB : S_LINK;
            else             st_q <= S_RD;
          end else begin
            widx_q <= widx_q + 2'd1;
          end
        end
        S_RD: if (mem_ack_i) begin
          data_q <= mem_rdata_i;
          st_q   <= S_WR;
        end
        S_WR: if (mem_ack_i) begin
          if (ctrl_q[CB_SINC]) src_q <= src_q + STEP_A;
          if (ctrl_q[CB_DINC]) dst_q <= dst_q + STEP_A;
          cnt_q <= cnt_q - DW'(1);
          if (cnt_q == DW'(1)) begin
            widx_q <= 2'd0;
            st_q   <= ctrl_q[CB_WB] ? S_WB : S_LINK;
          end else begin
            st_q <= S_RD;
          end
        end
        S_WB: if (mem_ack_i) begin
          if (widx_q == 2'd1) st_q <= S_LINK;
          widx_q <= 2'd1;
        end
        S_LINK: begin
          widx_q <= 2'd0;
          if (ctrl_q[CB_CHAIN]) begin
            ptr_q <= ptr_q + DESC_SZ;
            st_q  <= S_DESC;
          end else begin
            irq_q <= ctrl_q[CB_IRQ];
            st_q  <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_xfer.sv
module chain_xfer #(
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter int          NREQ     = 4,
  parameter logic [31:0] VEC_BASE = 32'h0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREQ-1:0] act_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            busy_o,
  output logic            irq_o
);
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic            gnt_vld, take;
  logic [IW-1:0]   gnt_idx;
  logic [NREQ-1:0] gnt_oh;

  chain_xfer_arb #(.NREQ(NREQ), .IW(IW)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act_i),
    .take_i    (take),
    .gnt_vld_o (gnt_vld),
    .gnt_idx_o (gnt_idx),
    .gnt_oh_o  (gnt_oh)
  );

  chain_xfer_seq #(.AW(AW), .DW(DW), .IW(IW), .VEC_BASE(VEC_BASE)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gnt_vld_i   (gnt_vld),
    .gnt_idx_i   (gnt_idx),
    .take_o      (take),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/chain_xfer_chk.sv
module chain_xfer_chk #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NREQ = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic [DW-1:0]   mem_wdata_o,
  input logic            mem_ack_i,
  input logic            busy_o,
  input logic            irq_o,
  input logic [NREQ-1:0] gnt_oh
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R9
  AST_WDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !mem_ack_i |=> $stable(mem_wdata_o)); // R9
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R6
  AST_IRQ_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy_o); // R6
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R10
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && (|gnt_oh) |=> busy_o); // R10
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_oh)); // R8
endmodule

bind chain_xfer chain_xfer_chk #(.AW(AW), .DW(DW), .NREQ(NREQ)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .busy_o      (busy_o),
  .irq_o       (irq_o),
  .gnt_oh      (gnt_oh)
);

// File: tb/chain_xfer_bench.sv
module chain_xfer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  act = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0, busy, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  int total = 0;
  int bad   = 0;

  logic [31:0] mem  [1024];
  logic [31:0] rlog [1024];
  int rlog_n = 0;
  int irq_n  = 0;
  int viol_n = 0;
  logic        pend_chk = 1'b0;
  logic [31:0] pend_addr = '0;
  logic        pend_we = 1'b0;

  always #2.5 clk = ~clk;

  chain_xfer u_chain_xfer (
    .clk_i(clk), .rst_ni(rst_n), .act_i(act),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .irq_o(irq)
  );

  // memory model: acks one cycle after a new request, logs reads, checks hold
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (pend_chk && (!mem_req || mem_addr != pend_addr || mem_we != pend_we))
      viol_n <= viol_n + 1;
    pend_chk <= 1'b0;
    if (rst_n && mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      pend_chk  <= 1'b1;
      pend_addr <= mem_addr;
      pend_we   <= mem_we;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else begin
        mem_rdata <= mem[mem_addr[11:2]];
        rlog[rlog_n % 1024] <= mem_addr;
        rlog_n <= rlog_n + 1;
      end
    end
    if (irq) irq_n <= irq_n + 1;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    mem[a[11:2]] = d;
  endtask

  task automatic desc(input logic [31:0] p, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] n, input logic [31:0] c);
    wr(p, s); wr(p + 4, d); wr(p + 8, n); wr(p + 12, c);
  endtask

  task automatic pulse(input int k);
    @(negedge clk); act[k] = 1'b1;
    @(negedge clk); act = '0;
  endtask

  task automatic wait_idle();
    int idle = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (busy) idle = 0; else idle++;
      if (idle >= 4) return;
    end
    check("R10 idle timeout", 32'd1, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 req",  {31'd0, mem_req}, 32'd0);
    check("R1 irq",  {31'd0, irq}, 32'd0);
  endtask

  task automatic t_single();
    int b = rlog_n;
    int q = irq_n;
    wr(32'h0, 32'h100);
    desc(32'h100, 32'h400, 32'h500, 4, 32'hE);
    pulse(0);
    @(negedge clk);
    check("R10 busy after accept", {31'd0, busy}, 32'd1);
    wait_idle();
    check("R2 vector read", rlog[b], 32'h0);
    for (int i = 0; i < 4; i++) check("R2 record word", rlog[b + 1 + i], 32'h100 + 4 * i);
    check("R3 first data read", rlog[b + 5], 32'h400);
    for (int i = 0; i < 4; i++) check("R3 copy inc", mem[(32'h500 >> 2) + i], 32'hA0 + i);
    check("R6 irq single", irq_n - q, 1);
  endtask

  task automatic t_fixed();
    int q = irq_n;
    wr(32'h4, 32'h140);
    wr(32'h60C, 32'hDEAD);
    desc(32'h140, 32'h404, 32'h600, 3, 32'h8);
    pulse(1); wait_idle();
    for (int i = 0; i < 3; i++) check("R3 fixed src", mem[(32'h600 >> 2) + i], 32'hA1);
    check("R3 dst bound", mem[32'h60C >> 2], 32'hDEAD);
    wr(32'h8, 32'h180);
    wr(32'h704, 32'hBEEF);
    desc(32'h180, 32'h400, 32'h700, 3, 32'h4);
    pulse(2); wait_idle();
    check("R3 fixed dst", mem[32'h700 >> 2], 32'hA2);
    check("R3 fixed dst bound", mem[32'h704 >> 2], 32'hBEEF);
    check("R6 no irq bit", irq_n - q, 0);
  endtask

  task automatic t_zero();
    int b = rlog_n;
    int q = irq_n;
    wr(32'hC, 32'h1C0);
    wr(32'h780, 32'h5A5A);
    desc(32'h1C0, 32'h400, 32'h780, 0, 32'hA);
    pulse(3); wait_idle();
    check("R4 no data reads", rlog_n - b, 5);
    check("R4 dst untouched", mem[32'h780 >> 2], 32'h5A5A);
    check("R4 irq still", irq_n - q, 1);
  endtask

  task automatic t_chain();
    int q = irq_n;
    wr(32'h0, 32'h200);
    desc(32'h200, 32'h400, 32'h800, 2, 32'hF);
    desc(32'h210, 32'h410, 32'h808, 1, 32'hD);
    desc(32'h220, 32'h408, 32'h80C, 2, 32'hE);
    pulse(0); wait_idle();
    check("R5 link0 w0", mem[32'h800 >> 2], 32'hA0);
    check("R5 link0 w1", mem[32'h804 >> 2], 32'hA1);
    check("R5 link1",    mem[32'h808 >> 2], 32'hA4);
    check("R5 link2 w0", mem[32'h80C >> 2], 32'hA2);
    check("R5 link2 w1", mem[32'h810 >> 2], 32'hA3);
    check("R6 one irq per chain", irq_n - q, 1);
    q = irq_n;
    wr(32'h4, 32'h240);
    desc(32'h240, 32'h400, 32'h820, 1, 32'hF);
    desc(32'h250, 32'h404, 32'h824, 1, 32'hC);
    pulse(1); wait_idle();
    check("R5 second link", mem[32'h824 >> 2], 32'hA1);
    check("R6 last without irq", irq_n - q, 0);
  endtask

  task automatic t_wb();
    wr(32'h8, 32'h280);
    desc(32'h280, 32'h400, 32'h880, 3, 32'h1C);
    pulse(2); wait_idle();
    check("R7 src back", mem[32'h280 >> 2], 32'h40C);
    check("R7 dst back", mem[32'h284 >> 2], 32'h88C);
    check("R7 count kept", mem[32'h288 >> 2], 32'd3);
    check("R7 data", mem[32'h888 >> 2], 32'hA2);
  endtask

  task automatic t_pend();
    int b = rlog_n;
    int nv = 0;
    logic [31:0] seq [3];
    wr(32'hC, 32'h2C0); wr(32'h4, 32'h300); wr(32'h8, 32'h340);
    desc(32'h2C0, 32'h400, 32'h900, 20, 32'h8);
    desc(32'h300, 32'h400, 32'h9A0, 1, 32'hC);
    desc(32'h340, 32'h404, 32'h9B0, 1, 32'hC);
    pulse(3);
    @(negedge clk);
    check("R10 busy", {31'd0, busy}, 32'd1);
    pulse(2); pulse(1); pulse(1);
    check("R8 still busy", {31'd0, busy}, 32'd1);
    wait_idle();
    for (int i = b; i < rlog_n; i++) begin
      if (rlog[i % 1024] < 32'h10) begin
        if (nv < 3) seq[nv] = rlog[i % 1024];
        nv++;
      end
    end
    check("R8 served count", nv, 3);
    check("R8 order first",  seq[0], 32'hC);
    check("R8 order second", seq[1], 32'h4);
    check("R8 order third",  seq[2], 32'h8);
    check("R8 src1 data", mem[32'h9A0 >> 2], 32'hA0);
    check("R8 src2 data", mem[32'h9B0 >> 2], 32'hA1);
    check("R3 long fixed", mem[(32'h900 >> 2) + 19], 32'hA0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < 8; i++) mem[(32'h400 >> 2) + i] = 32'hA0 + i;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_fixed();
    t_zero();
    t_chain();
    t_wb();
    t_pend();
    check("R9 handshake hold", viol_n, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule